// File: doc/BRIEF.md
# Command List Register Writer

This block turns a stream of 32-bit command words into byte-masked writes on a register file. Software builds the list in memory. A fetch unit outside this block streams the words in over a valid/ready handshake. The block decodes each command, merges every write into its register file, and reports each write on a one-cycle strobe so that downstream handlers can react to particular registers.

A command starts with its data word, and the header word comes second. The header names the target register, a four-bit byte-lane mask, a count of extra data words and a group flag. Extra words either hit the same register again or step through consecutive registers. Every command starts at an even word offset from the start of the list, so a single padding word is skipped whenever the previous command ended on an odd offset. The run is started with a pulse that carries the list length in words. Parsing stops once that many words have been taken.

Top module: `clw_top`

## Requirements
- R1: A write with mask bit g set replaces byte g of the target register (bits 8g+7..8g) with the matching byte of the data word; bytes whose mask bit is clear keep their old contents.
- R2: Each command is a data word followed by a header word with the register id in bits 15:0, the byte mask in bits 19:16, the extra-word count in bits 27:20 and the group flag in bit 31; the header word causes the first write.
- R3: A command with extra-word count N takes exactly N further words, each producing one write, and all of them use the header's byte mask.
- R4: With the group flag set, extra word k (counting from 1) targets id+k; with the flag clear, every extra word targets the header id.
- R5: When a command would start at an odd word offset from the list start, one padding word is consumed first and produces no write.
- R6: A write whose target id (computed without wrap) is at or above NUM_REGS leaves every register unchanged, still strobes, raises wr_err, and carries the data word ANDed with the expanded byte mask on wr_data.
- R7: A start pulse while idle loads the list length and raises busy; parsing ends after exactly that many words have been taken, a length of zero takes no words, and a command cut short by the length ends without further writes (a data word with no header writes nothing).
- R8: in_ready is high only while busy and words of the list remain; cycles with in_valid low do not change the result.
- R9: Each write raises wr_valid for exactly one cycle, in the cycle after the word that completes it is taken, with wr_id and the merged value on wr_data; the register file shows the new value from that same cycle on the read port.
- R10: After reset every register reads zero, and busy, in_ready and wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin parsing a list (taken only while idle) |
| list_len | input | LEN_W | Length of the list in words, sampled with start |
| busy | output | 1 | A list is being parsed |
| in_valid | input | 1 | Command word on in_data is valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Block takes the word this cycle if in_valid is high |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_id | output | 16 | Register id of the write (low 16 bits) |
| wr_data | output | 32 | Merged register value (masked data word for a dropped write) |
| wr_err | output | 1 | Write targeted an id at or above NUM_REGS and was dropped |
| rd_id | input | 16 | Register read address |
| rd_data | output | 32 | Register contents at rd_id (zero when out of range) |

## Verification
The bound checker watches, on every cycle, that the bytes enabled by the mask on a kept write carry the data word, that a dropped write shows the masked data word, that a padding word never produces a strobe, that in_ready never rises outside a run, that a start pulse while idle raises busy, and that every strobe follows a taken word. Register contents that a write must leave alone, the targets chosen across a burst, the even-offset skipping, truncation by the length, and stall tolerance all depend on the whole command history. Only the bench's scenarios show those, comparing each strobe and a full readback of the register file against an arithmetic model.

// File: rtl/clw_pkg.sv
package clw_pkg;

   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;
   localparam int ID_W   = 16;
   localparam int EXT_W  = 8;

   typedef struct packed {
      logic             grp;
      logic [EXT_W-1:0] ext;
      logic [LANES-1:0] mask;
      logic [ID_W-1:0]  id;
   } clw_hdr_t;

   typedef enum logic [1:0] {
      S_IDLE,
      S_VALUE,
      S_HEADER,
      S_EXTRA
   } clw_state_t;

   // Header layout: id 15:0, mask 19:16, extra count 27:20, group 31
   function automatic clw_hdr_t clw_decode(input logic [WORD_W-1:0] w);
      clw_hdr_t h;
      h.id   = w[15:0];
      h.mask = w[19:16];
      h.ext  = w[27:20];
      h.grp  = w[31];
      return h;
   endfunction

endpackage

// File: rtl/clw_parser.sv
module clw_parser
   import clw_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  list_len,
   output logic              busy,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              we,
   output logic [ID_W:0]     we_id,
   output logic [WORD_W-1:0] we_val,
   output logic [LANES-1:0]  we_mask,
   output logic              pad_take
);

   clw_state_t        state_q;
   logic [LEN_W-1:0]  pos_q;
   logic [LEN_W-1:0]  len_q;
   logic [WORD_W-1:0] val_q;
   logic [ID_W:0]     id_q;
   logic [LANES-1:0]  mask_q;
   logic [EXT_W-1:0]  left_q;
   logic              grp_q;

   logic     words_left;
   logic     take;
   clw_hdr_t hdr;

   assign hdr        = clw_decode(in_data);
   assign words_left = (pos_q != len_q);
   assign busy       = (state_q != S_IDLE);
   assign in_ready   = busy && words_left;
   assign take       = in_valid && in_ready;
   assign pad_take   = take && (state_q == S_VALUE) && pos_q[0];

   always_comb begin
      we      = take && ((state_q == S_HEADER) || (state_q == S_EXTRA));
      we_id   = grp_q ? id_q + 1'b1 : id_q;
      we_val  = in_data;
      we_mask = mask_q;
      if (state_q == S_HEADER) begin
         we_id   = {1'b0, hdr.id};
         we_val  = val_q;
         we_mask = hdr.mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pos_q   <= '0;
         len_q   <= '0;
         val_q   <= '0;
         id_q    <= '0;
         mask_q  <= '0;
         left_q  <= '0;
         grp_q   <= 1'b0;
      end else if (state_q == S_IDLE) begin
         if (start) begin
            len_q   <= list_len;
            pos_q   <= '0;
            state_q <= S_VALUE;
         end
      end else if (!words_left) begin
         state_q <= S_IDLE;
      end else if (take) begin
         pos_q <= pos_q + 1'b1;
         unique case (state_q)
            S_VALUE: begin
               if (!pos_q[0]) begin
                  val_q   <= in_data;
                  state_q <= S_HEADER;
               end
            end
            S_HEADER: begin
               id_q    <= {1'b0, hdr.id};
               mask_q  <= hdr.mask;
               grp_q   <= hdr.grp;
               left_q  <= hdr.ext;
               state_q <= (hdr.ext != '0) ? S_EXTRA : S_VALUE;
            end
            S_EXTRA: begin
               id_q   <= we_id;
               left_q <= left_q - 1'b1;
               if (left_q == EXT_W'(1)) state_q <= S_VALUE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/clw_regfile.sv
module clw_regfile
   import clw_pkg::*;
#(
   parameter int NUM_REGS = 1024,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ID_W:0]     we_id,
   input  logic [WORD_W-1:0] we_val,
   input  logic [LANES-1:0]  we_mask,
   input  logic [ID_W-1:0]   rd_id,
   output logic [WORD_W-1:0] rd_data,
   output logic [WORD_W-1:0] merged,
   output logic              drop
);

   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_REGS);

   logic [WORD_W-1:0] mem [NUM_REGS];
   logic [WORD_W-1:0] old;

   assign drop = (we_id >= LIMIT);
   assign old  = drop ? '0 : mem[we_id[IDX_W-1:0]];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[8*g +: 8] = we_mask[g] ? we_val[8*g +: 8] : old[8*g +: 8];
   end

   assign rd_data = ({1'b0, rd_id} >= LIMIT) ? '0 : mem[rd_id[IDX_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (we && !drop) begin
         mem[we_id[IDX_W-1:0]] <= merged;
      end
   end

endmodule

// File: rtl/clw_strobe.sv
module clw_strobe
   import clw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ID_W-1:0]   we_id,
   input  logic [WORD_W-1:0] merged,
   input  logic              drop,
   output logic              wr_valid,
   output logic [ID_W-1:0]   wr_id,
   output logic [WORD_W-1:0] wr_data,
   output logic              wr_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_id    <= '0;
         wr_data  <= '0;
         wr_err   <= 1'b0;
      end else begin
         wr_valid <= we;
         if (we) begin
            wr_id   <= we_id;
            wr_data <= merged;
            wr_err  <= drop;
         end
      end
   end

endmodule

// File: rtl/clw_top.sv
module clw_top
   import clw_pkg::*;
#(
   parameter int NUM_REGS = 1024,
   parameter int LEN_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  list_len,
   output logic              busy,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              wr_valid,
   output logic [ID_W-1:0]   wr_id,
   output logic [WORD_W-1:0] wr_data,
   output logic              wr_err,
   input  logic [ID_W-1:0]   rd_id,
   output logic [WORD_W-1:0] rd_data
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (NUM_REGS < 2 || NUM_REGS > (1 << ID_W)) begin : g_bad_regs
      $error("clw_top: NUM_REGS must lie in 2 .. 2**ID_W");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("clw_top: LEN_W must be at least 2");
   end

   logic              we;
   logic [ID_W:0]     we_id;
   logic [WORD_W-1:0] we_val;
   logic [LANES-1:0]  we_mask;
   logic              pad_take;
   logic [WORD_W-1:0] merged;
   logic              drop;

   clw_parser #(.LEN_W(LEN_W)) i_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .list_len (list_len),
      .busy     (busy),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .we       (we),
      .we_id    (we_id),
      .we_val   (we_val),
      .we_mask  (we_mask),
      .pad_take (pad_take)
   );

   clw_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .we_id   (we_id),
      .we_val  (we_val),
      .we_mask (we_mask),
      .rd_id   (rd_id),
      .rd_data (rd_data),
      .merged  (merged),
      .drop    (drop)
   );

   clw_strobe i_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .we_id    (we_id[ID_W-1:0]),
      .merged   (merged),
      .drop     (drop),
      .wr_valid (wr_valid),
      .wr_id    (wr_id),
      .wr_data  (wr_data),
      .wr_err   (wr_err)
   );

endmodule

// File: rtl/clw_checker.sv
module clw_checker
   import clw_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              in_valid,
   input logic              in_ready,
   input logic              wr_valid,
   input logic [WORD_W-1:0] wr_data,
   input logic              wr_err,
   input logic [WORD_W-1:0] we_val,
   input logic [LANES-1:0]  we_mask,
   input logic              pad_take
);

   function automatic logic [WORD_W-1:0] lanes(input logic [LANES-1:0] m);
      logic [WORD_W-1:0] r;
      for (int g = 0; g < LANES; g++) r[8*g +: 8] = {8{m[g]}};
      return r;
   endfunction

   // R1: enabled bytes of a kept write carry the data word
   p_lane_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_err |-> ((wr_data ^ $past(we_val)) & lanes($past(we_mask))) == '0);

   // R6: a dropped write shows the masked data word
   p_drop_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_err |-> wr_data == ($past(we_val) & lanes($past(we_mask))));

   // R5: padding word never strobes
   p_pad_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pad_take |=> !wr_valid);

   // R8: ready only during a run
   p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   // R7: start while idle begins a run
   p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R9: a strobe follows a taken word
   p_strobe_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(in_valid && in_ready));

endmodule

bind clw_top clw_checker i_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .wr_valid (wr_valid),
   .wr_data  (wr_data),
   .wr_err   (wr_err),
   .we_val   (we_val),
   .we_mask  (we_mask),
   .pad_take (pad_take)
);

// File: tb/test_clw_top.sv
module test_clw_top;

   localparam int CLK_PERIOD = 10;
   localparam int NREGS      = 16;
   localparam int LW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] list_len = '0;
   logic          busy;
   logic          in_valid = 1'b0;
   logic [31:0]   in_data = '0;
   logic          in_ready;
   logic          wr_valid;
   logic [15:0]   wr_id;
   logic [31:0]   wr_data;
   logic          wr_err;
   logic [15:0]   rd_id = '0;
   logic [31:0]   rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   clw_top #(.NUM_REGS(NREGS), .LEN_W(LW)) i_clw_top (
      .clk(clk), .rst_n(rst_n), .start(start), .list_len(list_len), .busy(busy),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .wr_valid(wr_valid), .wr_id(wr_id), .wr_data(wr_data), .wr_err(wr_err),
      .rd_id(rd_id), .rd_data(rd_data)
   );

   int          nchk = 0;
   int          nerr = 0;
   string       cur_tag = "R9";
   logic [31:0] mdl [NREGS];
   logic [31:0] wq [$];
   logic [15:0] q_id [$];
   logic [31:0] q_dat [$];
   logic        q_err [$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(int id, int m, int ext, int grp);
      return {grp[0], 3'b000, ext[7:0], m[3:0], id[15:0]};
   endfunction

   function automatic logic [31:0] lanes(logic [3:0] m);
      logic [31:0] r;
      for (int g = 0; g < 4; g++) r[8*g +: 8] = {8{m[g]}};
      return r;
   endfunction

   function automatic void mdl_write(int id, logic [31:0] v, logic [3:0] m);
      logic [31:0] lm = lanes(m);
      logic        err = (id >= NREGS);
      logic [31:0] d = err ? (v & lm) : ((mdl[id] & ~lm) | (v & lm));
      if (!err) mdl[id] = d;
      q_id.push_back(id[15:0]);
      q_dat.push_back(d);
      q_err.push_back(err);
   endfunction

   // model of the list walk, R2 R3 R4 R5 R7
   function automatic void mdl_parse(int len);
      int pos = 0;
      while (pos < len) begin
         if (pos % 2 == 1) begin pos++; continue; end
         if (pos + 1 >= len) break;
         begin
            logic [31:0] v = wq[pos];
            logic [31:0] h = wq[pos+1];
            int id = int'(h[15:0]);
            int ext = int'(h[27:20]);
            pos += 2;
            mdl_write(id, v, h[19:16]);
            for (int k = 1; k <= ext; k++) begin
               if (pos >= len) break;
               mdl_write(h[31] ? id + k : id, wq[pos], h[19:16]);
               pos++;
            end
         end
      end
   endfunction

   task automatic add_cmd(logic [31:0] v, int id, int m, int ext, int grp);
      if (wq.size() % 2 == 1) wq.push_back(32'hDEAD_0000 | wq.size());
      wq.push_back(v);
      wq.push_back(hdr(id, m, ext, grp));
      for (int k = 1; k <= ext; k++) wq.push_back(v ^ (32'h1111_1111 * k));
   endtask

   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (q_id.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL %s R9 unexpected strobe actual=%h expected=none", cur_tag, wr_id);
         end else begin
            chk({cur_tag, " R9 id"},   {16'h0, wr_id}, {16'h0, q_id.pop_front()});
            chk({cur_tag, " R1 data"}, wr_data,        q_dat.pop_front());
            chk({cur_tag, " R6 err"},  {31'h0, wr_err}, {31'h0, q_err.pop_front()});
         end
      end
   end

   task automatic readback(string tag);
      for (int i = 0; i < NREGS; i++) begin
         @(negedge clk);
         rd_id = 16'(i);
         #1;
         chk(tag, rd_data, mdl[i]);
      end
   endtask

   task automatic run_list(string tag, int len, bit gaps);
      int idx = 0;
      int cyc = 0;
      cur_tag = tag;
      mdl_parse(len);
      @(negedge clk);
      start = 1'b1;
      list_len = LW'(len);
      @(negedge clk);
      start = 1'b0;
      while (busy && idx < wq.size()) begin
         bit gap = gaps && (cyc % 3 == 1);
         cyc++;
         in_valid = !gap;
         in_data = wq[idx];
         if (!gap && in_ready) idx++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk({tag, " R7 words taken"}, idx, (len < wq.size()) ? len : wq.size());
      chk({tag, " R9 strobes pending"}, q_id.size(), 0);
      chk({tag, " R8 ready idle"}, {31'h0, in_ready}, 0);
      readback({tag, " R1 readback"});
      wq.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREGS; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      chk("R10 busy", {31'h0, busy}, 0);
      chk("R10 ready", {31'h0, in_ready}, 0);
      chk("R10 strobe", {31'h0, wr_valid}, 0);
      rst_n = 1'b1;
      readback("R10 regs zero");

      // R1 R2: every mask, one register each, then chained merges on one register
      for (int m = 0; m < 16; m++) add_cmd(32'hA0B0C0D0 ^ (32'h0101_0101 * m), m, m, 0, 0);
      run_list("R1 mask sweep", wq.size(), 0);
      for (int m = 0; m < 16; m++) add_cmd(32'h1234_5678 + (32'h0F0F_0F0F * m), 5, m, 0, 0);
      run_list("R1 merge chain", wq.size(), 0);

      // R3 R4 R5: burst lengths and group flag, trailing command checks padding
      for (int ext = 0; ext <= 5; ext++) begin
         for (int grp = 0; grp <= 1; grp++) begin
            add_cmd(32'h5A00_0000 + ext * 16 + grp, 2, (ext % 2) ? 4'hF : 4'h6, ext, grp);
            add_cmd(32'hC3C3_0000 + ext, 9, 4'hF, 0, 0);
            run_list(grp ? "R4 group burst" : "R3 repeat burst", wq.size(), 0);
         end
      end
      add_cmd(32'h0000_00AA, 1, 4'h1, 1, 1);
      add_cmd(32'h0000_BB00, 1, 4'h2, 3, 0);
      add_cmd(32'h00CC_0000, 3, 4'h4, 0, 0);
      run_list("R5 padding", wq.size(), 0);

      // R6: ids at or beyond the register count
      add_cmd(32'hFFFF_FFFF, 20, 4'hF, 0, 0);
      add_cmd(32'h7777_7777, 14, 4'h5, 3, 1);
      add_cmd(32'h2222_2222, 16'hFFFF, 4'hA, 2, 1);
      run_list("R6 out of range", wq.size(), 0);

      // R7: zero length, truncated burst, value word alone
      add_cmd(32'h9999_9999, 4, 4'hF, 0, 0);
      run_list("R7 zero length", 0, 0);
      add_cmd(32'h4444_4444, 6, 4'hF, 4, 1);
      run_list("R7 truncated burst", 3, 0);
      add_cmd(32'h8888_8888, 7, 4'hF, 0, 0);
      run_list("R7 value only", 1, 0);

      // R8: stalls on the input
      for (int ext = 0; ext <= 3; ext++) add_cmd(32'h0BAD_F00D + ext, 8 + ext, 4'h9 + ext, ext, ext % 2);
      run_list("R8 stalled input", wq.size(), 1);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule